// File: doc/BRIEF.md
# Saturation and Zero-Byte Compare Unit

This unit sits beside the ALU of a 32-bit datapath and produces two kinds of result. The first is a saturating move: the source word is clamped to the signed byte range or the signed halfword range, or it goes through a word saturate. The word saturate does not clamp by value. It reads the incoming condition (overflow) bit and, when that bit is set, replaces the source with the signed boundary on the opposite side of the source's sign. The second is a lane test that sets the condition bit when any of the four bytes of the source is zero.

A saturating move is requested with `sat_req`, and the move is chosen by a 16-bit immediate sub-field. A zero-byte test is requested with `zb_req`. Both requests may be raised in the same cycle. All outputs are registered, so every result appears one clock after its request. The condition output follows the condition input whenever a saturating request is taken, is rewritten by the zero-byte test, and holds when the unit is idle.

Top module: `sat_zb_unit`

## Requirements
- R1: While reset (`rst_n` low) is held, `res_valid`, `res_data` and `cond_out` are all 0.
- R2: Sub-field 0x0300 selects the byte saturate. The result is 127 when the signed source is 127 or more, -128 when it is -128 or less, and the source unchanged otherwise.
- R3: Sub-field 0x0200 selects the halfword saturate. The result is 32767 when the signed source is 32767 or more, -32768 when it is -32768 or less, and the source unchanged otherwise.
- R4: Sub-field 0x0000 selects the word saturate. With `cond_in` = 0 it returns the source unchanged.
- R5: In the word saturate with `cond_in` = 1, the result is 0x7FFFFFFF for a negative source and 0x80000000 for a zero or positive source.
- R6: Any sub-field value other than 0x0300, 0x0200 and 0x0000 gives no result: `res_valid` stays 0 and `res_data` keeps its previous value.
- R7: A zero-byte test sets `cond_out` to 1 on the next cycle if any of the source's bytes [7:0], [15:8], [23:16] or [31:24] equals zero, and to 0 otherwise.
- R8: A saturating request without a zero-byte test does not alter the condition bit: on the next cycle `cond_out` equals the `cond_in` that came with the request. This holds for unrecognised sub-fields too.
- R9: A saturating request with a recognised sub-field raises `res_valid` for exactly the next cycle and places the result on `res_data` in that same cycle.
- R10: When both requests come in the same cycle, the saturate uses the incoming `cond_in`, and `cond_out` takes the zero-byte test result.
- R11: In a cycle with no request, `res_valid` goes to 0 on the next cycle, and `res_data` and `cond_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sat_req | input | 1 | Requests a saturating move this cycle |
| sub_field | input | 16 | Immediate sub-field that selects the saturating move |
| zb_req | input | 1 | Requests a zero-byte test this cycle |
| src | input | 32 | Source word |
| cond_in | input | 1 | Current condition bit |
| res_valid | output | 1 | `res_data` holds a new result |
| res_data | output | 32 | Saturated result |
| cond_out | output | 1 | Updated condition bit |

## Verification
The saturating move and the zero-byte test can both be requested in one cycle. When that happens, the word saturate must read the old condition bit while the zero-byte test writes the new one. The bench provokes this directly: it issues both requests with `cond_in` set and with sources chosen so that the test's verdict differs from `cond_in`. It also raises both requests in a long run of random stimulus. The behavioural reference model resolves each such cycle on its own: it takes the result from the old condition bit and the new condition bit from the lane test. A design that feeds its new condition bit back into the word saturate, or that lets one request mask the other, then differs from the model on `res_data` or on `cond_out`.

// File: rtl/sat_zb_pkg.sv
package sat_zb_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_BYTE = 2'd1,
    SEL_HALF = 2'd2,
    SEL_WORD = 2'd3
  } sat_sel_e;

  // Signed clamp of v into the range of a keep-bit two's-complement value.
  function automatic logic [WORD_W-1:0] clamp_to(input logic [WORD_W-1:0] v,
                                                 input int keep);
    logic [WORD_W-1:0]        one;
    logic signed [WORD_W-1:0] hi;
    logic signed [WORD_W-1:0] lo;
    logic signed [WORD_W-1:0] sv;
    one = 1;
    hi  = $signed((one << (keep - 1)) - one);
    lo  = ~hi;
    sv  = $signed(v);
    if (sv >= hi)      return hi;
    else if (sv <= lo) return lo;
    else               return v;
  endfunction

  // Overflow-driven boundary: the bound opposite to the (wrapped) sign of v.
  function automatic logic [WORD_W-1:0] word_boundary(input logic [WORD_W-1:0] v,
                                                      input logic ovf);
    if (!ovf)              return v;
    else if (v[WORD_W-1])  return {1'b0, {(WORD_W-1){1'b1}}};
    else                   return {1'b1, {(WORD_W-1){1'b0}}};
  endfunction

endpackage

// File: rtl/sat_decode.sv
module sat_decode
  import sat_zb_pkg::*;
#(
  parameter int unsigned FIELD_W = 16,
  parameter logic [FIELD_W-1:0] CODE_BYTE = 'h0300,
  parameter logic [FIELD_W-1:0] CODE_HALF = 'h0200,
  parameter logic [FIELD_W-1:0] CODE_WORD = 'h0000
) (
  input  logic [FIELD_W-1:0] field,
  output sat_sel_e           sel,
  output logic               sel_ok
);

  always_comb begin
    sel = SEL_NONE;
    if (field == CODE_BYTE)      sel = SEL_BYTE;
    else if (field == CODE_HALF) sel = SEL_HALF;
    else if (field == CODE_WORD) sel = SEL_WORD;
  end

  assign sel_ok = (sel != SEL_NONE);

endmodule

// File: rtl/sat_path.sv
module sat_path
  import sat_zb_pkg::*;
#(
  parameter int unsigned DATA_W    = WORD_W,
  parameter int          BYTE_KEEP = 8,
  parameter int          HALF_KEEP = 16
) (
  input  logic [DATA_W-1:0] src,
  input  logic              ovf,
  input  sat_sel_e          sel,
  output logic [DATA_W-1:0] y
);

  logic [DATA_W-1:0] byte_y;
  logic [DATA_W-1:0] half_y;
  logic [DATA_W-1:0] word_y;

  assign byte_y = clamp_to(src, BYTE_KEEP);
  assign half_y = clamp_to(src, HALF_KEEP);
  assign word_y = word_boundary(src, ovf);

  always_comb begin
    unique case (sel)
      SEL_BYTE: y = byte_y;
      SEL_HALF: y = half_y;
      SEL_WORD: y = word_y;
      default:  y = src;
    endcase
  end

endmodule

// File: rtl/zbyte_detect.sv
module zbyte_detect #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0]        src,
  output logic [DATA_W/LANE_W-1:0] lane_zero,
  output logic                     hit
);

  localparam int unsigned LANES = DATA_W / LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_zero[g] = ~|src[g*LANE_W +: LANE_W];
  end

  assign hit = |lane_zero;

endmodule

// File: rtl/sat_zb_unit.sv
module sat_zb_unit
  import sat_zb_pkg::*;
#(
  parameter int unsigned DATA_W    = WORD_W,
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned FIELD_W   = 16,
  parameter int          BYTE_KEEP = 8,
  parameter int          HALF_KEEP = 16,
  parameter logic [FIELD_W-1:0] CODE_BYTE = 'h0300,
  parameter logic [FIELD_W-1:0] CODE_HALF = 'h0200,
  parameter logic [FIELD_W-1:0] CODE_WORD = 'h0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sat_req,
  input  logic [FIELD_W-1:0] sub_field,
  input  logic               zb_req,
  input  logic [DATA_W-1:0]  src,
  input  logic               cond_in,
  output logic               res_valid,
  output logic [DATA_W-1:0]  res_data,
  output logic               cond_out
);

  localparam int unsigned LANES    = DATA_W / LANE_W;
  localparam int          BYTE_MAX = (2 ** (BYTE_KEEP - 1)) - 1;
  localparam int          HALF_MAX = (2 ** (HALF_KEEP - 1)) - 1;

  // Named internal events
  sat_sel_e          sel;
  logic              sel_ok;
  logic              sat_fire;
  logic [DATA_W-1:0] sat_y;
  logic [LANES-1:0]  lane_zero;
  logic              zb_hit;
  sat_sel_e          kind_q;

  sat_decode #(
    .FIELD_W  (FIELD_W),
    .CODE_BYTE(CODE_BYTE),
    .CODE_HALF(CODE_HALF),
    .CODE_WORD(CODE_WORD)
  ) u_decode (
    .field (sub_field),
    .sel   (sel),
    .sel_ok(sel_ok)
  );

  sat_path #(
    .DATA_W   (DATA_W),
    .BYTE_KEEP(BYTE_KEEP),
    .HALF_KEEP(HALF_KEEP)
  ) u_path (
    .src(src),
    .ovf(cond_in),
    .sel(sel),
    .y  (sat_y)
  );

  zbyte_detect #(
    .DATA_W(DATA_W),
    .LANE_W(LANE_W)
  ) u_zb (
    .src      (src),
    .lane_zero(lane_zero),
    .hit      (zb_hit)
  );

  assign sat_fire = sat_req & sel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      cond_out  <= 1'b0;
      kind_q    <= SEL_NONE;
    end else begin
      res_valid <= sat_fire;
      if (sat_fire) begin
        res_data <= sat_y;
        kind_q   <= sel;
      end
      if (zb_req)       cond_out <= zb_hit;
      else if (sat_req) cond_out <= cond_in;
    end
  end

  // R9
  sat_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_req && sel_ok |=> res_valid && res_data == $past(sat_y));

  // R6
  bad_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_req && !sel_ok |=> !res_valid && $stable(res_data));

  // R8
  cond_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_req && !zb_req |=> cond_out == $past(cond_in));

  // R7
  zb_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zb_req |=> cond_out == $past(|lane_zero));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sat_req && !zb_req |=> !res_valid && $stable(cond_out) && $stable(res_data));

  // R2
  byte_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && kind_q == SEL_BYTE |->
      $signed(res_data) <= BYTE_MAX && $signed(res_data) >= -BYTE_MAX - 1);

  // R3
  half_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && kind_q == SEL_HALF |->
      $signed(res_data) <= HALF_MAX && $signed(res_data) >= -HALF_MAX - 1);

  // R5
  word_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_req && sel == SEL_WORD && cond_in |=>
      res_data[DATA_W-1] != $past(src[DATA_W-1]));

endmodule

// File: tb/sat_zb_unit_tb.sv
module sat_zb_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sat_req = 1'b0;
  logic [15:0] sub_field = 16'h0;
  logic        zb_req = 1'b0;
  logic [31:0] src = 32'h0;
  logic        cond_in = 1'b0;
  logic        res_valid;
  logic [31:0] res_data;
  logic        cond_out;

  int compared = 0;
  int mismatched = 0;

  // reference state
  logic        e_valid = 1'b0;
  logic [31:0] e_data = 32'h0;
  logic        e_cond = 1'b0;
  string       e_tag = "R1";

  always #10 clk = ~clk;

  sat_zb_unit u_dut (
    .clk(clk), .rst_n(rst_n), .sat_req(sat_req), .sub_field(sub_field),
    .zb_req(zb_req), .src(src), .cond_in(cond_in),
    .res_valid(res_valid), .res_data(res_data), .cond_out(cond_out)
  );

  function automatic logic [31:0] ref_clamp(input logic [31:0] s, input integer lim);
    integer v;
    v = $signed(s);
    if (v >= lim)       return lim;
    if (v <= -lim - 1)  return -lim - 1;
    return s;
  endfunction

  function automatic logic ref_zero(input logic [31:0] s);
    for (int i = 0; i < 4; i++)
      if (((s >> (8 * i)) & 32'hFF) == 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic compare_now();
    compared++;
    if (res_valid !== e_valid || (e_valid && res_data !== e_data) ||
        res_data !== e_data || cond_out !== e_cond) begin
      mismatched++;
      $display("FAIL %s: got valid=%0b data=%08h cond=%0b, expected valid=%0b data=%08h cond=%0b",
               e_tag, res_valid, res_data, cond_out, e_valid, e_data, e_cond);
    end
  endtask

  task automatic step(input bit sr, input logic [15:0] f, input bit zr,
                      input logic [31:0] s, input bit c, input string tag);
    logic        nv;
    logic [31:0] nd;
    logic        nc;
    @(negedge clk);
    compare_now();
    sat_req = sr; sub_field = f; zb_req = zr; src = s; cond_in = c;
    nv = 1'b0; nd = e_data; nc = e_cond;
    if (sr) begin
      case (f)
        16'h0300: begin nv = 1'b1; nd = ref_clamp(s, 127);   end
        16'h0200: begin nv = 1'b1; nd = ref_clamp(s, 32767); end
        16'h0000: begin
          nv = 1'b1;
          if (!c) nd = s;
          else    nd = ($signed(s) < 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
        end
        default: ;
      endcase
    end
    if (zr)      nc = ref_zero(s);
    else if (sr) nc = c;
    e_valid = nv; e_data = nd; e_cond = nc; e_tag = tag;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin : stim
    logic [15:0] fsel [5];
    fsel[0] = 16'h0300; fsel[1] = 16'h0200; fsel[2] = 16'h0000;
    fsel[3] = 16'h0100; fsel[4] = 16'h0301;

    // R1: reset state
    repeat (2) @(negedge clk);
    compare_now();
    rst_n = 1'b1;

    // R2 byte saturate
    step(1, 16'h0300, 0, 32'd127, 0, "R2");
    step(1, 16'h0300, 0, 32'd128, 1, "R2");
    step(1, 16'h0300, 0, 32'd126, 0, "R2");
    step(1, 16'h0300, 0, -32'sd128, 0, "R2");
    step(1, 16'h0300, 0, -32'sd129, 1, "R2");
    step(1, 16'h0300, 0, 32'h8000_0000, 0, "R2");
    step(1, 16'h0300, 0, 32'h7FFF_FFFF, 0, "R2");
    step(1, 16'h0300, 0, -32'sd5, 0, "R2");
    // R3 halfword saturate
    step(1, 16'h0200, 0, 32'd32767, 0, "R3");
    step(1, 16'h0200, 0, 32'd32768, 0, "R3");
    step(1, 16'h0200, 0, -32'sd32768, 1, "R3");
    step(1, 16'h0200, 0, -32'sd32769, 0, "R3");
    step(1, 16'h0200, 0, 32'd1000, 0, "R3");
    // R4 word saturate, no overflow
    step(1, 16'h0000, 0, 32'h8000_0001, 0, "R4");
    step(1, 16'h0000, 0, 32'h1234_5678, 0, "R4");
    // R5 word saturate with overflow
    step(1, 16'h0000, 0, 32'hFFFF_FFFF, 1, "R5");
    step(1, 16'h0000, 0, 32'h0000_0000, 1, "R5");
    step(1, 16'h0000, 0, 32'h7FFF_0000, 1, "R5");
    // R6 unrecognised sub-fields
    step(1, 16'h0100, 0, 32'd999, 1, "R6");
    step(1, 16'hFFFF, 0, 32'd5, 0, "R6");
    step(1, 16'h0301, 0, 32'd500, 1, "R6");
    // R7 zero-byte test
    step(0, 16'h0300, 1, 32'h0102_0304, 1, "R7");
    step(0, 16'h0300, 1, 32'h0011_2233, 0, "R7");
    step(0, 16'h0300, 1, 32'h1100_2233, 0, "R7");
    step(0, 16'h0300, 1, 32'h1122_0033, 0, "R7");
    step(0, 16'h0300, 1, 32'h1122_3300, 0, "R7");
    step(0, 16'h0300, 1, 32'hFFFF_FFFF, 1, "R7");
    step(0, 16'h0300, 1, 32'h0000_0000, 0, "R7");
    // R8 saturate leaves condition bit as given
    step(1, 16'h0200, 0, 32'd7, 1, "R8");
    step(1, 16'h0300, 0, 32'd7, 0, "R8");
    step(1, 16'h0400, 0, 32'd7, 1, "R8");
    // R9 latency: back-to-back results
    step(1, 16'h0300, 0, 32'd300, 0, "R9");
    step(1, 16'h0200, 0, 32'd300, 0, "R9");
    // R10 both requests in one cycle
    step(1, 16'h0000, 1, 32'h8011_2233, 1, "R10");
    step(1, 16'h0000, 1, 32'h1100_0000, 1, "R10");
    step(1, 16'h0300, 1, 32'h0000_0100, 0, "R10");
    // R11 idle cycles hold
    step(0, 16'h0300, 0, 32'h0, 0, "R11");
    step(0, 16'h0000, 0, 32'hFFFF_FFFF, 1, "R11");

    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] rs;
      int k;
      k = $urandom_range(0, 3);
      rs = $urandom;
      if (k == 0)      rs = $signed($urandom_range(0, 600)) - 300;
      else if (k == 1) rs = $signed($urandom_range(0, 80000)) - 40000;
      else if (k == 2) rs = rs & {{8{$urandom_range(0,1) == 1}}, 8'hFF, 8'hFF, {8{$urandom_range(0,1) == 1}}};
      step($urandom_range(0, 3) != 0, fsel[$urandom_range(0, 4)],
           $urandom_range(0, 2) == 0, rs, $urandom_range(0, 1) == 1, "R10");
    end
    step(0, 16'h0, 0, 32'h0, 0, "R11");
    @(negedge clk);
    compare_now();
    finish_run();
  end

endmodule